// File: doc/BRIEF.md
# Serial CRC Engine with Run-Time Generator Polynomial

This block computes a cyclic redundancy check one message bit per clock. The generator polynomial is not built in as fixed XOR taps. It comes in on a port as its low-order coefficients; the leading term is implied by the width and is never stored. A thermometer mask selects the degree r, from 3 to 32. One engine can therefore serve a 3-bit toy code, CRC-8 and CRC-32 without being rebuilt.

Each message bit is combined at the top of the remainder register rather than at the bottom. This multiplies the message by x^r as it enters. After every accepted bit, the register already holds the finished checksum of the bits received so far, and no run of r zero bits has to be fed in at the end.

On the receive side, the engine compares the remainder against a fixed residue constant, masked to the active width. When the sender complemented its checksum before appending it, an error-free frame leaves exactly that residue. A one-cycle completion pulse marks the end of each burst of bits.

Top module: `serial_crc_engine`

## Requirements
- R1: The active degree r is given by `width_mask`, which has bits [r-1:0] set and every other bit clear, with r between 3 and 32. After a start or an accepted bit, every bit of `crc_out` at position r or above reads zero.
- R2: A high `start` clears `crc_out` to zero at the next clock edge. A bit offered with `bit_valid` in the same cycle as `start` is ignored.
- R3: For each accepted bit, the feedback bit f is `crc_out[r-1]` XOR `bit_in`. The new value is `crc_out` shifted left by one and masked to r bits, XORed with `gen_taps` masked to r bits when f is 1. The new value is visible after the clock edge that accepts the bit.
- R4: After each accepted bit, `crc_out` equals (message so far · x^r) mod G, where G = x^r + `gen_taps`. For example, with r=3 and taps 011, the message 1, 10, 100 gives 011, 110, 111.
- R5: In a cycle with both `bit_valid` and `start` low, `crc_out` and `match_out` hold their values whatever `bit_in` does.
- R6: `match_out` is registered together with `crc_out`. It is high exactly when the new remainder equals `CHECK_RESIDUE` masked to r bits. With the default residue 0xC704DD7B, a CRC-32 frame (taps 0x04C11DB7) whose appended checksum was complemented, and sent most significant bit first, ends with `match_out` high.
- R7: `done_out` is high for exactly one clock. It rises at the edge that ends the first cycle in which `bit_valid` and `start` are both low after one or more accepted bits. `crc_out` is unchanged from the last accepted bit.
- R8: A message of N bits offered on N consecutive cycles is fully processed after N clock edges, with no flush. For example, a 32-bit message under CRC-8 (r=8, taps 0x07) is done after 32 edges.
- R9: A synchronous active-high `rst` sets `crc_out` to zero and clears `match_out` and `done_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Clear the remainder to begin a new frame |
| bit_valid | input | 1 | `bit_in` carries a message bit this cycle |
| bit_in | input | 1 | Serial message bit |
| gen_taps | input | W | Generator coefficients x^0..x^(r-1), top term implied |
| width_mask | input | W | Thermometer mask of the active degree r |
| crc_out | output | W | Current remainder, bits r and above zero |
| match_out | output | 1 | Remainder equals the masked residue constant |
| done_out | output | 1 | One-cycle pulse after a burst of bits ends |

## Verification
The assertions assume that `width_mask` is a legal thermometer code with at least three ones whenever a bit is offered. They also assume that the mask and the taps stay unchanged from the start of a frame to its last bit. The upper-bit check and the shift check compare against the mask of the previous cycle on that basis. The stimulus draws r, the taps and the message from a seeded random source, and it changes the mask and taps only in the cycle that raises `start`. Random idle gaps and start pulses inside a frame exercise the hold and completion rules without breaking those assumptions.

// File: rtl/crc_ser_pkg.sv
package crc_ser_pkg;

  // Burst tracking for the completion pulse
  typedef enum logic {
    FR_IDLE = 1'b0,
    FR_RUN  = 1'b1
  } frame_state_t;

endpackage

// File: rtl/crc_width_decode.sv
module crc_width_decode #(
  parameter int W = 32
) (
  input  logic [W-1:0] width_mask,
  output logic [W-1:0] top_sel,
  output logic         mask_ok
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    // highest set bit of a thermometer mask marks position r-1
    top_sel = width_mask & ~(width_mask >> 1);
    mask_ok = ((width_mask & (width_mask + ONE)) == '0) && (&width_mask[2:0]);
  end
endmodule

// File: rtl/crc_bit_step.sv
module crc_bit_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] taps,
  input  logic [W-1:0] width_mask,
  input  logic [W-1:0] top_sel,
  input  logic         bit_in,
  output logic [W-1:0] nxt
);
  logic fb;

  always_comb begin
    fb  = (|(cur & top_sel)) ^ bit_in;
    nxt = ((cur << 1) & width_mask) ^ (fb ? (taps & width_mask) : '0);
  end
endmodule

// File: rtl/crc_frame_ctl.sv
module crc_frame_ctl
  import crc_ser_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic bit_valid,
  output logic done
);
  frame_state_t st;
  logic         idle_cyc;

  assign idle_cyc = !bit_valid && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= FR_IDLE;
      done <= 1'b0;
    end else begin
      done <= (st == FR_RUN) && idle_cyc;
      st   <= (bit_valid && !start) ? FR_RUN : FR_IDLE;
    end
  end

  // R7: completion is a single-cycle pulse
  p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: the pulse only follows a cycle with no bit and no start
  p_done_after_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(idle_cyc));

  // R7: an idle cycle right after a burst always produces the pulse
  p_done_fires_r7: assert property (@(posedge clk) disable iff (rst)
    (st == FR_RUN && idle_cyc) |=> done);
endmodule

// File: rtl/serial_crc_engine.sv
module serial_crc_engine #(
  parameter int           W             = 32,
  parameter logic [W-1:0] CHECK_RESIDUE = W'(32'hC704DD7B)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         bit_valid,
  input  logic         bit_in,
  input  logic [W-1:0] gen_taps,
  input  logic [W-1:0] width_mask,
  output logic [W-1:0] crc_out,
  output logic         match_out,
  output logic         done_out
);
  logic [W-1:0] top_sel;
  logic         mask_ok;
  logic [W-1:0] crc_next;
  logic [W-1:0] residue_m;
  logic         accept;

  assign residue_m = CHECK_RESIDUE & width_mask;
  assign accept    = bit_valid && !start;

  crc_width_decode #(.W(W)) u_width (
    .width_mask (width_mask),
    .top_sel    (top_sel),
    .mask_ok    (mask_ok)
  );

  crc_bit_step #(.W(W)) u_step (
    .cur        (crc_out),
    .taps       (gen_taps),
    .width_mask (width_mask),
    .top_sel    (top_sel),
    .bit_in     (bit_in),
    .nxt        (crc_next)
  );

  crc_frame_ctl u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .bit_valid (bit_valid),
    .done      (done_out)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_out   <= '0;
      match_out <= 1'b0;
    end else if (start) begin
      crc_out   <= '0;
      match_out <= (residue_m == '0);
    end else if (bit_valid) begin
      crc_out   <= crc_next;
      match_out <= (crc_next == residue_m);
    end
  end

  // R1: offered bits come with a legal thermometer width of at least 3
  p_mask_legal_r1: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (mask_ok && $countones(top_sel) == 1));

  // R1: nothing survives above the active width after an update
  p_upper_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (bit_valid || start) |=> ((crc_out & ~$past(width_mask)) == '0));

  // R2: start empties the remainder, even with a bit offered
  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    start |=> (crc_out == '0));

  // R3: zero feedback means a plain masked shift
  p_plain_shift_r3: assert property (@(posedge clk) disable iff (rst)
    (accept && ((|(crc_out & top_sel)) == bit_in))
      |=> (crc_out == (($past(crc_out) << 1) & $past(width_mask))));

  // R5: idle cycles leave remainder and flag alone
  p_hold_idle_r5: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !start) |=> ($stable(crc_out) && $stable(match_out)));
endmodule

// File: tb/test_serial_crc_engine.sv
`timescale 1ns/1ps
module test_serial_crc_engine;
  localparam logic [31:0] RES32 = 32'hC704DD7B;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic [31:0] gen_taps = '0;
  logic [31:0] width_mask = 32'h7;
  logic [31:0] crc_out;
  logic        match_out;
  logic        done_out;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  logic [31:0] m_crc, m_taps;
  logic        m_match, m_done, m_run;
  int          m_r;

  always #4 clk = ~clk;

  serial_crc_engine #(.W(32)) i_serial_crc_engine (
    .clk(clk), .rst(rst), .start(start), .bit_valid(bit_valid), .bit_in(bit_in),
    .gen_taps(gen_taps), .width_mask(width_mask),
    .crc_out(crc_out), .match_out(match_out), .done_out(done_out)
  );

  function automatic logic [31:0] mask_of(int r);
    logic [32:0] t;
    t = (33'd1 << r) - 33'd1;
    return t[31:0];
  endfunction

  // polynomial long division with the explicit top term
  function automatic logic [31:0] ref_step(logic [31:0] c, logic [31:0] taps, int r, logic b);
    logic [32:0] w, g;
    g = {1'b0, taps} | (33'd1 << r);
    w = ({1'b0, c} << 1) ^ ({32'd0, b} << r);
    if (w[r]) w = w ^ g;
    return w[31:0] & mask_of(r);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one clock: drive at a falling edge, model at the rising edge, compare at the next falling edge
  task automatic cycle(input logic s, input logic v, input logic b);
    logic nd;
    start = s; bit_valid = v; bit_in = b;
    @(posedge clk);
    nd = m_run && !v && !s;
    if (s) begin
      m_crc = '0;
      m_match = ((RES32 & mask_of(m_r)) == '0);
    end else if (v) begin
      m_crc = ref_step(m_crc, m_taps, m_r, b);
      m_match = (m_crc == (RES32 & mask_of(m_r)));
    end
    m_done = nd;
    m_run = v && !s;
    @(negedge clk);
    chk(crc_out === m_crc, "R3 R4 remainder", crc_out, m_crc);
    chk(match_out === m_match, "R6 match", {31'd0, match_out}, {31'd0, m_match});
    chk(done_out === m_done, "R7 done", {31'd0, done_out}, {31'd0, m_done});
    chk((crc_out & ~mask_of(m_r)) == '0, "R1 upper bits", crc_out, crc_out & mask_of(m_r));
  endtask

  task automatic set_code(input int r, input logic [31:0] taps);
    m_r = r; m_taps = taps;
    width_mask = mask_of(r); gen_taps = taps;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] saved, rem, msg;
    int r, len, nvalid;
    void'($urandom(32'h5EED_0C2C));
    m_crc = '0; m_match = 1'b0; m_done = 1'b0; m_run = 1'b0;
    set_code(3, 32'h3);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R9: reset state
    chk(crc_out === '0 && match_out === 1'b0 && done_out === 1'b0, "R9 reset",
        {crc_out[29:0], match_out, done_out}, 32'd0);

    // R3 R4: G = x^3 + x + 1, messages 1, 10, 100
    cycle(1'b1, 1'b0, 1'b0);
    cycle(1'b0, 1'b1, 1'b1); chk(crc_out === 32'h3, "R4 x^3 mod G", crc_out, 32'h3);
    cycle(1'b0, 1'b1, 1'b0); chk(crc_out === 32'h6, "R4 x^4 mod G", crc_out, 32'h6);
    cycle(1'b0, 1'b1, 1'b0); chk(crc_out === 32'h7, "R3 feedback step", crc_out, 32'h7);
    // R7: pulse after the first idle cycle only
    cycle(1'b0, 1'b0, 1'b1); chk(done_out === 1'b1, "R7 done rises", {31'd0, done_out}, 32'd1);
    chk(crc_out === 32'h7, "R7 remainder stable", crc_out, 32'h7);
    cycle(1'b0, 1'b0, 1'b0); chk(done_out === 1'b0, "R7 done single", {31'd0, done_out}, 32'd0);

    // R5: idle with bit_in toggling
    saved = crc_out;
    for (int i = 0; i < 4; i++) cycle(1'b0, 1'b0, i[0]);
    chk(crc_out === saved, "R5 hold", crc_out, saved);

    // R2: start wins over an offered bit
    cycle(1'b0, 1'b1, 1'b1);
    cycle(1'b1, 1'b1, 1'b1);
    chk(crc_out === '0, "R2 start clears", crc_out, 32'd0);

    // R8: CRC-8 over 32 consecutive bits
    set_code(8, 32'h07);
    cycle(1'b1, 1'b0, 1'b0);
    msg = $urandom; rem = '0; nvalid = 0;
    for (int i = 31; i >= 0; i--) begin
      cycle(1'b0, 1'b1, msg[i]);
      rem = ref_step(rem, 32'h07, 8, msg[i]);
      nvalid++;
    end
    chk(nvalid == 32 && crc_out === rem, "R8 crc8 after 32 edges", crc_out, rem);
    cycle(1'b0, 1'b0, 1'b0);
    chk(done_out === 1'b1, "R8 done after burst", {31'd0, done_out}, 32'd1);

    // R6: CRC-32 frame with complemented checksum leaves the residue
    set_code(32, 32'h04C11DB7);
    cycle(1'b1, 1'b0, 1'b0);
    msg = $urandom; rem = '0;
    for (int i = 31; i >= 0; i--) begin
      cycle(1'b0, 1'b1, msg[i]);
      rem = ref_step(rem, 32'h04C11DB7, 32, msg[i]);
    end
    rem = ~rem;
    for (int i = 31; i >= 0; i--) cycle(1'b0, 1'b1, rem[i]);
    chk(match_out === 1'b1, "R6 residue match", {31'd0, match_out}, 32'd1);
    chk(crc_out === RES32, "R6 residue value", crc_out, RES32);
    // R6: single bit error in a fresh frame misses the residue
    cycle(1'b1, 1'b0, 1'b0);
    for (int i = 31; i >= 0; i--) cycle(1'b0, 1'b1, msg[i] ^ (i == 5));
    for (int i = 31; i >= 0; i--) cycle(1'b0, 1'b1, rem[i]);
    chk(match_out === 1'b0, "R6 corrupted frame", {31'd0, match_out}, 32'd0);

    // random frames: width, taps, length, gaps, occasional restart
    for (int f = 0; f < 40; f++) begin
      r = 3 + int'($urandom % 30);
      set_code(r, $urandom & mask_of(r));
      cycle(1'b1, 1'b0, 1'b0);
      len = 1 + int'($urandom % 48);
      for (int i = 0; i < len; i++) begin
        if ($urandom % 5 == 0) cycle(1'b0, 1'b0, 1'($urandom));
        else if ($urandom % 29 == 0) cycle(1'b1, 1'($urandom), 1'($urandom));
        else cycle(1'b0, 1'b1, 1'($urandom));
      end
      cycle(1'b0, 1'b0, 1'b0);
      cycle(1'b0, 1'b0, 1'b0);
    end

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule